// File: doc/BRIEF.md
# Two-Dimensional Banked Tile Memory

A 16x16 on-chip tile store whose elements are spread over several single-ported banks. A vector of parallel accesses can then be served in one clock, as long as the access pattern places every active lane in a different bank. Each (row, col) coordinate is turned into a bank number and an offset inside that bank. A compile-time parameter selects one of two mapping schemes.

The grid scheme splits the banks two ways along rows and four ways along columns. Any 2x4 window therefore lands in eight distinct banks. The diagonal scheme uses eight banks indexed by the coordinate sum. Eight neighbouring elements of one row are then served together, and so are elements of neighbouring rows in one column, with half the bank count a full grid for both patterns would need.

The block has one vector read port and one vector write port, each with eight lanes. Every lane carries its own enable and coordinates. Read data returns on the lane that asked for it, one clock later. Each port raises its own conflict flag in the same cycle whenever two enabled lanes collide on a bank. The lowest-numbered colliding lane is then served and the others are dropped.

Top module: `tmem_banked_tile`

## Requirements
- R1: Grid scheme: two enabled lanes collide exactly when their row mod 2 and col mod 4 are both equal. The bank is (row mod 2)*4 + col mod 4 and the offset is (row div 2)*4 + col div 4.
- R2: Diagonal scheme: two enabled lanes collide exactly when (row + col) mod 8 is equal. The bank is (row + col) mod 8 and the offset is row*2 + col div 8.
- R3: Grid scheme: any window of 2 consecutive rows by 4 consecutive columns, one element per lane, is served in one cycle with no conflict.
- R4: Diagonal scheme: 8 consecutive columns of one row, or the same column of 2 consecutive rows, are served in one cycle with no conflict.
- R5: Each of the 256 locations keeps its own value. Every location written reads back unchanged through either scheme.
- R6: A read enabled in cycle n presents its data on that lane's slice of rd_data (lane i occupies bits i*16 to i*16+15) in cycle n+1, and only then.
- R7: rd_conflict and wr_conflict are combinational and cover their own port only. A single enabled lane never raises them, and two lanes with the same coordinate always do.
- R8: On a write conflict, only the lowest-numbered lane of each colliding group is stored. The other lanes' writes are discarded.
- R9: On a read conflict, the lowest-numbered colliding lane receives its data, and every other lane of that group reads zero.
- R10: A lane with its enable low writes nothing, and it reads zero in the following cycle.
- R11: A read and a write of the same location in the same cycle return the value held before that write. The new value is seen from the next read on.
- R12: After reset, all read lanes output zero, and both conflict flags are low while no lane is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 8 | Per-lane read enable |
| rd_row | input | 32 | Per-lane read row, 4 bits per lane |
| rd_col | input | 32 | Per-lane read column, 4 bits per lane |
| rd_data | output | 128 | Per-lane read data, 16 bits per lane, one cycle after the request |
| rd_conflict | output | 1 | Two enabled read lanes target one bank |
| wr_en | input | 8 | Per-lane write enable |
| wr_row | input | 32 | Per-lane write row, 4 bits per lane |
| wr_col | input | 32 | Per-lane write column, 4 bits per lane |
| wr_data | input | 128 | Per-lane write data, 16 bits per lane |
| wr_conflict | output | 1 | Two enabled write lanes target one bank |

## Verification
A wrong bank mapping first appears on a conflict flag in the same cycle as the offending request, because colliding pairs are applied directly against both schemes. A wrong offset, or a bank written from the wrong lane, shows up as a wrong word one cycle after the read that touches that location. A full write-then-read sweep of all 256 cells therefore exposes aliasing. A stale routing register shows up as data on the wrong lane, or as a non-zero lane, in the cycle right after a read.

// File: rtl/tmem_pkg.sv
package tmem_pkg;

    // Bank mapping selected at elaboration time
    typedef enum logic {
        SCHEME_GRID = 1'b0,
        SCHEME_DIAG = 1'b1
    } bank_scheme_e;

endpackage

// File: rtl/tmem_addr_map.sv
module tmem_addr_map #(
    parameter tmem_pkg::bank_scheme_e SCHEME = tmem_pkg::SCHEME_GRID,
    parameter int ROWS       = 16,
    parameter int COLS       = 16,
    parameter int ROW_BANKS  = 2,
    parameter int COL_BANKS  = 4,
    parameter int DIAG_BANKS = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int NBANKS = (SCHEME == tmem_pkg::SCHEME_GRID) ? ROW_BANKS * COL_BANKS : DIAG_BANKS,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int OFF_W  = $clog2(ROWS * COLS / NBANKS)
) (
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [OFF_W-1:0]  offset
);

    generate
        if (SCHEME == tmem_pkg::SCHEME_GRID) begin : g_grid
            localparam int RB_W = $clog2(ROW_BANKS);
            localparam int CB_W = $clog2(COL_BANKS);
            // low bits pick the bank, high bits pick the word inside it
            assign bank   = {row[RB_W-1:0], col[CB_W-1:0]};
            assign offset = {row[ROW_W-1:RB_W], col[COL_W-1:CB_W]};
        end else begin : g_diag
            localparam int DB_W = $clog2(DIAG_BANKS);
            logic [DB_W-1:0] diag_sum;
            // sum wraps modulo the bank count
            assign diag_sum = row[DB_W-1:0] + col[DB_W-1:0];
            assign bank     = diag_sum;
            assign offset   = {row, col[COL_W-1:DB_W]};
        end
    endgenerate

endmodule

// File: rtl/tmem_arbiter.sv
module tmem_arbiter #(
    parameter int LANES  = 8,
    parameter int NBANKS = 8,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  en,
    input  logic [BANK_W-1:0] bank [LANES],
    output logic [LANES-1:0]  grant,
    output logic              conflict,
    output logic [NBANKS-1:0] bank_busy,
    output logic [LANE_W-1:0] bank_lane [NBANKS]
);

    logic taken;

    // fixed priority: a lane loses if any lower enabled lane shares its bank
    always_comb begin
        grant    = '0;
        conflict = 1'b0;
        taken    = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            taken = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (en[j] && en[i] && (bank[j] == bank[i])) begin
                    taken = 1'b1;
                end
            end
            grant[i] = en[i] && !taken;
            conflict = conflict | taken;
        end
    end

    // per bank: which granted lane drives it (at most one by construction of grant)
    always_comb begin
        for (int b = 0; b < NBANKS; b++) begin
            bank_busy[b] = 1'b0;
            bank_lane[b] = '0;
            for (int i = 0; i < LANES; i++) begin
                if (grant[i] && (bank[i] == BANK_W'(b))) begin
                    bank_busy[b] = 1'b1;
                    bank_lane[b] = LANE_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/tmem_bank.sv
module tmem_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bank_state_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    bank_state_t       state_d;
    bank_state_t       state_q;

    // read samples the array before this cycle's write lands
    always_comb begin
        state_d = state_q;
        if (re) begin
            state_d.rdata = mem_q[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // storage array carries no reset
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = state_q.rdata;

endmodule

// File: rtl/tmem_banked_tile.sv
module tmem_banked_tile #(
    parameter tmem_pkg::bank_scheme_e SCHEME = tmem_pkg::SCHEME_GRID,
    parameter int ROWS       = 16,
    parameter int COLS       = 16,
    parameter int LANES      = 8,
    parameter int DATA_W     = 16,
    parameter int ROW_BANKS  = 2,
    parameter int COL_BANKS  = 4,
    parameter int DIAG_BANKS = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int NBANKS = (SCHEME == tmem_pkg::SCHEME_GRID) ? ROW_BANKS * COL_BANKS : DIAG_BANKS,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int DEPTH  = ROWS * COLS / NBANKS,
    localparam int OFF_W  = $clog2(DEPTH),
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        rd_en,
    input  logic [LANES*ROW_W-1:0]  rd_row,
    input  logic [LANES*COL_W-1:0]  rd_col,
    output logic [LANES*DATA_W-1:0] rd_data,
    output logic                    rd_conflict,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANES*ROW_W-1:0]  wr_row,
    input  logic [LANES*COL_W-1:0]  wr_col,
    input  logic [LANES*DATA_W-1:0] wr_data,
    output logic                    wr_conflict
);

    typedef struct packed {
        logic [LANES-1:0]             grant;
        logic [LANES-1:0][BANK_W-1:0] bank;
    } route_t;

    logic [BANK_W-1:0] rd_bank   [LANES];
    logic [OFF_W-1:0]  rd_off    [LANES];
    logic [BANK_W-1:0] wr_bank   [LANES];
    logic [OFF_W-1:0]  wr_off    [LANES];
    logic [DATA_W-1:0] wr_word   [LANES];
    logic [LANES-1:0]  rd_grant;
    logic [LANES-1:0]  wr_grant;
    logic [NBANKS-1:0] rd_busy;
    logic [NBANKS-1:0] wr_busy;
    logic [LANE_W-1:0] rd_lane   [NBANKS];
    logic [LANE_W-1:0] wr_lane   [NBANKS];
    logic [DATA_W-1:0] bank_rdata [NBANKS];
    route_t            route_d;
    route_t            route_q;

    // coordinate to (bank, offset) for every lane of both ports
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            tmem_addr_map #(
                .SCHEME(SCHEME), .ROWS(ROWS), .COLS(COLS),
                .ROW_BANKS(ROW_BANKS), .COL_BANKS(COL_BANKS), .DIAG_BANKS(DIAG_BANKS)
            ) u_rd_map (
                .row(rd_row[l*ROW_W +: ROW_W]),
                .col(rd_col[l*COL_W +: COL_W]),
                .bank(rd_bank[l]),
                .offset(rd_off[l])
            );
            tmem_addr_map #(
                .SCHEME(SCHEME), .ROWS(ROWS), .COLS(COLS),
                .ROW_BANKS(ROW_BANKS), .COL_BANKS(COL_BANKS), .DIAG_BANKS(DIAG_BANKS)
            ) u_wr_map (
                .row(wr_row[l*ROW_W +: ROW_W]),
                .col(wr_col[l*COL_W +: COL_W]),
                .bank(wr_bank[l]),
                .offset(wr_off[l])
            );
            assign wr_word[l] = wr_data[l*DATA_W +: DATA_W];
        end
    endgenerate

    tmem_arbiter #(.LANES(LANES), .NBANKS(NBANKS)) u_rd_arb (
        .en(rd_en),
        .bank(rd_bank),
        .grant(rd_grant),
        .conflict(rd_conflict),
        .bank_busy(rd_busy),
        .bank_lane(rd_lane)
    );

    tmem_arbiter #(.LANES(LANES), .NBANKS(NBANKS)) u_wr_arb (
        .en(wr_en),
        .bank(wr_bank),
        .grant(wr_grant),
        .conflict(wr_conflict),
        .bank_busy(wr_busy),
        .bank_lane(wr_lane)
    );

    // bank array: each bank fed by the lane that won it on each port
    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            tmem_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
                .clk(clk),
                .rst_n(rst_n),
                .we(wr_busy[b]),
                .waddr(wr_off[wr_lane[b]]),
                .wdata(wr_word[wr_lane[b]]),
                .re(rd_busy[b]),
                .raddr(rd_off[rd_lane[b]]),
                .rdata(bank_rdata[b])
            );
        end
    endgenerate

    // remember, per lane, whether it was served and from which bank
    always_comb begin
        route_d.grant = rd_grant;
        for (int i = 0; i < LANES; i++) begin
            route_d.bank[i] = rd_bank[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    // return path: bank output steered back to the requesting lane
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rd_data[i*DATA_W +: DATA_W] = route_q.grant[i] ? bank_rdata[route_q.bank[i]] : '0;
        end
    end

endmodule

// File: rtl/tmem_banked_tile_chk.sv
module tmem_banked_tile_chk #(
    parameter int LANES  = 8,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        rd_en,
    input logic [LANES*ROW_W-1:0]  rd_row,
    input logic [LANES*COL_W-1:0]  rd_col,
    input logic [LANES*DATA_W-1:0] rd_data,
    input logic                    rd_conflict,
    input logic [LANES-1:0]        rd_grant,
    input logic [LANES-1:0]        wr_en,
    input logic [LANES*ROW_W-1:0]  wr_row,
    input logic [LANES*COL_W-1:0]  wr_col,
    input logic                    wr_conflict,
    input logic [LANES-1:0]        wr_grant
);

    p_same_coord_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[0] && rd_en[1] && (rd_row[ROW_W-1:0] == rd_row[2*ROW_W-1:ROW_W])
            && (rd_col[COL_W-1:0] == rd_col[2*COL_W-1:COL_W])) |-> rd_conflict);

    p_same_coord_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && wr_en[1] && (wr_row[ROW_W-1:0] == wr_row[2*ROW_W-1:ROW_W])
            && (wr_col[COL_W-1:0] == wr_col[2*COL_W-1:COL_W])) |-> wr_conflict);

    p_single_lane_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_en) <= 1) |-> !rd_conflict);

    p_idle_lane_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en[0] |=> (rd_data[DATA_W-1:0] == '0));

    p_rd_grant_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_grant & ~rd_en) == '0));

    p_wr_grant_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_grant & ~wr_en) == '0));

    p_lane0_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en[0] |-> rd_grant[0]);

    p_lane0_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |-> wr_grant[0]);

endmodule

bind tmem_banked_tile tmem_banked_tile_chk #(
    .LANES(LANES), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .rd_en(rd_en),
    .rd_row(rd_row),
    .rd_col(rd_col),
    .rd_data(rd_data),
    .rd_conflict(rd_conflict),
    .rd_grant(rd_grant),
    .wr_en(wr_en),
    .wr_row(wr_row),
    .wr_col(wr_col),
    .wr_conflict(wr_conflict),
    .wr_grant(wr_grant)
);

// File: tb/tmem_banked_tile_tb.sv
`timescale 1ns/1ps
module tmem_banked_tile_tb;

    localparam int L  = 8;
    localparam int DW = 16;
    localparam int NV = 9;

    // {r0, c0, r1, c1, grid_conflict, diag_conflict}
    localparam logic [17:0] VEC [NV] = '{
        {4'd0,  4'd0,  4'd0, 4'd1, 1'b0, 1'b0},
        {4'd0,  4'd0,  4'd2, 4'd0, 1'b1, 1'b0},
        {4'd0,  4'd0,  4'd0, 4'd4, 1'b1, 1'b0},
        {4'd1,  4'd3,  4'd0, 4'd4, 1'b0, 1'b1},
        {4'd3,  4'd5,  4'd5, 4'd3, 1'b0, 1'b1},
        {4'd2,  4'd6,  4'd4, 4'd2, 1'b1, 1'b0},
        {4'd15, 4'd15, 4'd7, 4'd7, 1'b1, 1'b1},
        {4'd0,  4'd0,  4'd0, 4'd8, 1'b1, 1'b1},
        {4'd5,  4'd2,  4'd5, 4'd3, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [L-1:0]  rd_en = '0;
    logic [L*4-1:0] rd_row = '0;
    logic [L*4-1:0] rd_col = '0;
    logic [L-1:0]  wr_en = '0;
    logic [L*4-1:0] wr_row = '0;
    logic [L*4-1:0] wr_col = '0;
    logic [L*DW-1:0] wr_data = '0;
    logic [L*DW-1:0] rd_data_g;
    logic [L*DW-1:0] rd_data_d;
    logic rd_conf_g, wr_conf_g, rd_conf_d, wr_conf_d;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tmem_banked_tile #(.SCHEME(tmem_pkg::SCHEME_GRID)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data_g), .rd_conflict(rd_conf_g),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .wr_conflict(wr_conf_g)
    );

    tmem_banked_tile #(.SCHEME(tmem_pkg::SCHEME_DIAG)) u_dut_diag (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data_d), .rd_conflict(rd_conf_d),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .wr_conflict(wr_conf_d)
    );

    function automatic logic [DW-1:0] cell_val(input int r, input int c);
        return {4'hC, 4'h3, 4'(r), 4'(c)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_en = '0; rd_row = '0; rd_col = '0;
        wr_en = '0; wr_row = '0; wr_col = '0; wr_data = '0;
    endtask

    task automatic set_rd(input int lane, input int r, input int c);
        rd_en[lane] = 1'b1;
        rd_row[lane*4 +: 4] = 4'(r);
        rd_col[lane*4 +: 4] = 4'(c);
    endtask

    task automatic set_wr(input int lane, input int r, input int c, input logic [DW-1:0] d);
        wr_en[lane] = 1'b1;
        wr_row[lane*4 +: 4] = 4'(r);
        wr_col[lane*4 +: 4] = 4'(c);
        wr_data[lane*DW +: DW] = d;
    endtask

    function automatic logic [DW-1:0] lane_g(input int lane);
        return rd_data_g[lane*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] lane_d(input int lane);
        return rd_data_d[lane*DW +: DW];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 grid rd_data", 32'(rd_data_g == '0), 32'd1);
        chk("R12 diag rd_data", 32'(rd_data_d == '0), 32'd1);
        chk("R12 rd_conflict", {30'd0, rd_conf_g, rd_conf_d}, 32'd0);
        chk("R12 wr_conflict", {30'd0, wr_conf_g, wr_conf_d}, 32'd0);

        // R1 R2 R7: lane-pair mapping table on both ports
        for (int v = 0; v < NV; v++) begin
            idle();
            set_rd(0, int'(VEC[v][17:14]), int'(VEC[v][13:10]));
            set_rd(1, int'(VEC[v][9:6]),   int'(VEC[v][5:2]));
            set_wr(0, int'(VEC[v][17:14]), int'(VEC[v][13:10]), 16'h0);
            set_wr(1, int'(VEC[v][9:6]),   int'(VEC[v][5:2]),   16'h0);
            #1;
            chk("R1 grid rd_conflict", 32'(rd_conf_g), 32'(VEC[v][1]));
            chk("R1 grid wr_conflict", 32'(wr_conf_g), 32'(VEC[v][1]));
            chk("R2 diag rd_conflict", 32'(rd_conf_d), 32'(VEC[v][0]));
            chk("R2 diag wr_conflict", 32'(wr_conf_d), 32'(VEC[v][0]));
            @(negedge clk);
        end

        // R7: single lane never conflicts
        idle();
        set_rd(5, 7, 7);
        #1;
        chk("R7 single lane", {30'd0, rd_conf_g, rd_conf_d}, 32'd0);
        @(negedge clk);

        // R5: fill every cell through lane 0
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                idle();
                set_wr(0, r, c, cell_val(r, c));
                @(negedge clk);
            end
        end

        // R5 R6: read back every cell on a rotating lane
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                idle();
                set_rd((r + c) % 8, r, c);
                @(negedge clk);
                chk("R5 grid readback", 32'(lane_g((r + c) % 8)), 32'(cell_val(r, c)));
                chk("R5 diag readback", 32'(lane_d((r + c) % 8)), 32'(cell_val(r, c)));
            end
        end

        // R3: 2x4 window on grid scheme
        idle();
        for (int l = 0; l < 8; l++) set_rd(l, 6 + l / 4, 9 + l % 4);
        #1;
        chk("R3 grid window conflict", 32'(rd_conf_g), 32'd0);
        @(negedge clk);
        for (int l = 0; l < 8; l++) chk("R3 grid window data", 32'(lane_g(l)), 32'(cell_val(6 + l / 4, 9 + l % 4)));

        // R4: row of 8 on diagonal scheme
        idle();
        for (int l = 0; l < 8; l++) set_rd(l, 11, 5 + l);
        #1;
        chk("R4 diag row conflict", 32'(rd_conf_d), 32'd0);
        @(negedge clk);
        for (int l = 0; l < 8; l++) chk("R4 diag row data", 32'(lane_d(l)), 32'(cell_val(11, 5 + l)));

        // R4: column pair on diagonal scheme
        idle();
        set_rd(0, 4, 9);
        set_rd(1, 5, 9);
        #1;
        chk("R4 diag column conflict", 32'(rd_conf_d), 32'd0);
        @(negedge clk);
        chk("R4 diag column lane0", 32'(lane_d(0)), 32'(cell_val(4, 9)));
        chk("R4 diag column lane1", 32'(lane_d(1)), 32'(cell_val(5, 9)));

        // R9: read conflict on grid, lower lane wins, other reads zero
        idle();
        set_rd(2, 0, 0);
        set_rd(5, 2, 0);
        #1;
        chk("R9 grid rd_conflict", 32'(rd_conf_g), 32'd1);
        @(negedge clk);
        chk("R9 winner lane2", 32'(lane_g(2)), 32'(cell_val(0, 0)));
        chk("R9 loser lane5", 32'(lane_g(5)), 32'd0);

        // R8: write conflict on grid, different cells, same bank
        idle();
        set_wr(1, 4, 4, 16'h1111);
        set_wr(6, 6, 0, 16'h2222);
        #1;
        chk("R8 grid wr_conflict", 32'(wr_conf_g), 32'd1);
        @(negedge clk);
        idle();
        set_rd(0, 4, 4);
        @(negedge clk);
        chk("R8 winner stored", 32'(lane_g(0)), 32'h1111);
        idle();
        set_rd(0, 6, 0);
        @(negedge clk);
        chk("R8 loser dropped", 32'(lane_g(0)), 32'(cell_val(6, 0)));

        // R8: same-cell write on diagonal scheme
        idle();
        set_wr(0, 9, 9, 16'hAAAA);
        set_wr(3, 9, 9, 16'hBBBB);
        @(negedge clk);
        idle();
        set_rd(4, 9, 9);
        @(negedge clk);
        chk("R8 diag same cell", 32'(lane_d(4)), 32'hAAAA);

        // R10: disabled write lane leaves the cell alone
        idle();
        wr_row[4 +: 4] = 4'd1;
        wr_col[4 +: 4] = 4'd1;
        wr_data[DW +: DW] = 16'hDEAD;
        @(negedge clk);
        idle();
        set_rd(1, 1, 1);
        @(negedge clk);
        chk("R10 grid disabled write", 32'(lane_g(1)), 32'(cell_val(1, 1)));
        chk("R10 diag disabled write", 32'(lane_d(1)), 32'(cell_val(1, 1)));

        // R10: disabled read lane returns zero
        idle();
        rd_row[12 +: 4] = 4'd2;
        rd_col[12 +: 4] = 4'd2;
        @(negedge clk);
        chk("R10 disabled read lane", 32'(lane_g(3)), 32'd0);

        // R11: same-cycle read and write of one cell
        idle();
        set_wr(0, 3, 3, 16'h7777);
        set_rd(1, 3, 3);
        @(negedge clk);
        chk("R11 old value", 32'(lane_g(1)), 32'(cell_val(3, 3)));
        chk("R11 old value diag", 32'(lane_d(1)), 32'(cell_val(3, 3)));
        idle();
        set_rd(1, 3, 3);
        @(negedge clk);
        chk("R11 new value", 32'(lane_g(1)), 32'h7777);

        // R6: data present for exactly one cycle after the request
        idle();
        set_rd(2, 8, 8);
        @(negedge clk);
        chk("R6 data at n+1", 32'(lane_g(2)), 32'(cell_val(8, 8)));
        idle();
        @(negedge clk);
        chk("R6 zero at n+2", 32'(lane_g(2)), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule